// File: doc/BRIEF.md
# Prediction-Restriction Instruction Trap Checker

This block decides, for each issue of a privileged prediction-restriction system instruction, whether it may run or must be rerouted. It looks at the current privilege level (0 to 3), the per-level user-access enables, the hypervisor host-extension and trap-general bits, the nested-virtualization bit, the fine-grained-trap controls, and flags saying which higher levels exist. From these it produces one registered result code and a syndrome class, one cycle after the issue strobe.

The outcome is chosen by a fixed priority chain that depends on the privilege level. A missing feature overrides everything. At level 0, host mode (level 2 enabled with both the host-extension and trap-general bits set) switches to a separate user-enable check. Outside host mode the level-1 user-enable check comes first and the fine-grained trap second. At level 1 the nested-virtualization bit wins over the fine-grained trap. Levels 2 and 3 always run the instruction. The block uses a two-state machine: `ST_IDLE` (no result pending) and `ST_REPORT` (result valid this cycle). It takes `IDLE->REPORT` and `REPORT->REPORT` on an issue strobe, and `REPORT->IDLE` and `IDLE->IDLE` without one.

Top module: `spec_restrict_trap_chk`

## Requirements
- R1: While `rst_n` is low, `res_vld` is 0 and the state is `ST_IDLE`.
- R2: `res_vld` is 1 exactly in the cycle after each cycle with `issue_vld` high, and 0 after each cycle with `issue_vld` low. Back-to-back issues give back-to-back results.
- R3: When `feat_present` is 0, the code is 3 (undefined), whatever the level and the other controls.
- R4: At level 0 outside host mode with `usr_en_l1`=0, the code is 2 (trap to level 2) if level 2 is enabled (`lvl2_impl` and `lvl2_act` both 1) and `trap_gen`=1. Otherwise the code is 1 (trap to level 1).
- R5: At level 0 outside host mode with `usr_en_l1`=1, the code is 2 when the fine-grained condition holds, and 0 otherwise. The fine-grained condition is: level 2 enabled, `fgt_feat`=1, (`lvl3_impl`=0 or `fgt_top_en`=1), and `fgt_trap`=1.
- R6: At level 0 in host mode, `usr_en_l2`=0 gives code 2 and `usr_en_l2`=1 gives code 0. In host mode, `usr_en_l1` and the fine-grained controls have no effect.
- R7: At level 1, `nest_virt`=1 gives code 2 before any other check. Otherwise the fine-grained condition of R5 gives code 2, and without it the code is 0. `usr_en_l1` has no effect at level 1.
- R8: At levels 2 and 3 (with the feature present), the code is 0 regardless of all control bits.
- R9: `res_class` is 0x18 when the code is 1 or 2, and 0 when the code is 0 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_vld | input | 1 | Instruction issue strobe |
| cur_lvl | input | 2 | Current privilege level 0..3 |
| feat_present | input | 1 | Instruction feature implemented |
| lvl2_impl | input | 1 | Level 2 implemented |
| lvl2_act | input | 1 | Level 2 enabled for the current security state |
| lvl3_impl | input | 1 | Level 3 implemented |
| usr_en_l1 | input | 1 | Level-1 user-access enable |
| usr_en_l2 | input | 1 | Level-2 user-access enable (host mode) |
| host_ext | input | 1 | Hypervisor host-extension bit |
| trap_gen | input | 1 | Hypervisor trap-general bit |
| nest_virt | input | 1 | Nested-virtualization trap bit |
| fgt_feat | input | 1 | Fine-grained trap feature present |
| fgt_top_en | input | 1 | Top-level fine-grained enable |
| fgt_trap | input | 1 | Fine-grained trap bit for this instruction |
| res_vld | output | 1 | Result valid pulse |
| res_code | output | 2 | 0 execute, 1 trap to level 1, 2 trap to level 2, 3 undefined |
| res_class | output | 6 | Syndrome class (0x18 on trap, else 0) |

## Verification
Every result is due exactly one clock edge after its issue strobe. The driver applies inputs on a falling edge, and the matching result is sampled on the next falling edge. The driver pushes the expected code and class into a queue when it applies an issue. The monitor samples on every falling edge and pops one entry each time `res_vld` is high. It flags a valid result with nothing pending, and it flags any entry left over at the end, so a missing or extra pulse is caught. Idle gaps between bursts check that `res_vld` falls in the cycle after the strobe drops.

// File: rtl/srt_pkg.sv
package srt_pkg;
    typedef enum logic [1:0] {
        OUT_EXEC    = 2'd0,
        OUT_TRAP_L1 = 2'd1,
        OUT_TRAP_L2 = 2'd2,
        OUT_UNDEF   = 2'd3
    } srt_out_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } srt_state_e;
endpackage

// File: rtl/srt_fgt_gate.sv
module srt_fgt_gate (
    input  logic el2_en,
    input  logic fgt_feat,
    input  logic lvl3_impl,
    input  logic fgt_top_en,
    input  logic fgt_trap,
    output logic fgt_hit
);
    logic top_allows;

    always_comb begin
        top_allows = !lvl3_impl || fgt_top_en;
        fgt_hit    = el2_en && fgt_feat && top_allows && fgt_trap;
    end
endmodule

// File: rtl/srt_lvl0_path.sv
module srt_lvl0_path
    import srt_pkg::*;
(
    input  logic     host,
    input  logic     el2_en,
    input  logic     trap_gen,
    input  logic     usr_en_l1,
    input  logic     usr_en_l2,
    input  logic     fgt_hit,
    output srt_out_e out
);
    always_comb begin
        if (host) begin
            out = usr_en_l2 ? OUT_EXEC : OUT_TRAP_L2;
        end else if (!usr_en_l1) begin
            out = (el2_en && trap_gen) ? OUT_TRAP_L2 : OUT_TRAP_L1;
        end else if (fgt_hit) begin
            out = OUT_TRAP_L2;
        end else begin
            out = OUT_EXEC;
        end
    end
endmodule

// File: rtl/spec_restrict_trap_chk.sv
module spec_restrict_trap_chk
    import srt_pkg::*;
#(
    parameter int          LVL_W     = 2,
    parameter int          CLASS_W   = 6,
    parameter logic [5:0]  TRAP_CLASS = 6'h18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_vld,
    input  logic [LVL_W-1:0]   cur_lvl,
    input  logic               feat_present,
    input  logic               lvl2_impl,
    input  logic               lvl2_act,
    input  logic               lvl3_impl,
    input  logic               usr_en_l1,
    input  logic               usr_en_l2,
    input  logic               host_ext,
    input  logic               trap_gen,
    input  logic               nest_virt,
    input  logic               fgt_feat,
    input  logic               fgt_top_en,
    input  logic               fgt_trap,
    output logic               res_vld,
    output logic [1:0]         res_code,
    output logic [CLASS_W-1:0] res_class
);
    localparam logic [LVL_W-1:0] LVL0 = LVL_W'(0);
    localparam logic [LVL_W-1:0] LVL1 = LVL_W'(1);

    srt_state_e state_q, state_d;
    srt_out_e   l0_out, dec_out, code_q;
    logic       el2_en, host, fgt_hit;

    assign el2_en = lvl2_impl && lvl2_act;
    assign host   = el2_en && host_ext && trap_gen;

    srt_fgt_gate u_fgt (
        .el2_en     (el2_en),
        .fgt_feat   (fgt_feat),
        .lvl3_impl  (lvl3_impl),
        .fgt_top_en (fgt_top_en),
        .fgt_trap   (fgt_trap),
        .fgt_hit    (fgt_hit)
    );

    srt_lvl0_path u_l0 (
        .host      (host),
        .el2_en    (el2_en),
        .trap_gen  (trap_gen),
        .usr_en_l1 (usr_en_l1),
        .usr_en_l2 (usr_en_l2),
        .fgt_hit   (fgt_hit),
        .out       (l0_out)
    );

    always_comb begin
        if (!feat_present) begin
            dec_out = OUT_UNDEF;
        end else if (cur_lvl == LVL0) begin
            dec_out = l0_out;
        end else if (cur_lvl == LVL1) begin
            if (nest_virt || fgt_hit) dec_out = OUT_TRAP_L2;
            else                      dec_out = OUT_EXEC;
        end else begin
            dec_out = OUT_EXEC;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = issue_vld ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = issue_vld ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         code_q <= OUT_EXEC;
        else if (issue_vld) code_q <= dec_out;
    end

    always_comb begin
        res_vld   = (state_q == ST_REPORT);
        res_code  = code_q;
        res_class = ((code_q == OUT_TRAP_L1) || (code_q == OUT_TRAP_L2))
                    ? CLASS_W'(TRAP_CLASS) : '0;
    end
endmodule

// File: rtl/srt_chk.sv
module srt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       issue_vld,
    input logic [1:0] cur_lvl,
    input logic       feat_present,
    input logic       nest_virt,
    input logic       res_vld,
    input logic [1:0] res_code,
    input logic [5:0] res_class
);
    AST_VLD_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |=> res_vld);                                           // R2
    AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_vld |=> !res_vld);                                         // R2
    AST_UNDEF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && !feat_present) |=> (res_code == 2'd3));             // R3
    AST_NV_TRAPS_L2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && feat_present && cur_lvl == 2'd1 && nest_virt)
        |=> (res_code == 2'd2));                                          // R7
    AST_HIGH_LVL_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && feat_present && cur_lvl[1]) |=> (res_code == 2'd0)); // R8
    AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && (res_code == 2'd1 || res_code == 2'd2))
        |-> (res_class == 6'h18));                                        // R9
    AST_NOTRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && (res_code == 2'd0 || res_code == 2'd3))
        |-> (res_class == 6'h00));                                        // R9
endmodule

bind spec_restrict_trap_chk srt_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_vld    (issue_vld),
    .cur_lvl      (cur_lvl),
    .feat_present (feat_present),
    .nest_virt    (nest_virt),
    .res_vld      (res_vld),
    .res_code     (res_code),
    .res_class    (res_class)
);

// File: tb/spec_restrict_trap_chk_tb_top.sv
module spec_restrict_trap_chk_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_vld = 1'b0;
    logic [1:0] cur_lvl = 2'd0;
    logic feat_present = 1'b0, lvl2_impl = 1'b0, lvl2_act = 1'b0, lvl3_impl = 1'b0;
    logic usr_en_l1 = 1'b0, usr_en_l2 = 1'b0, host_ext = 1'b0, trap_gen = 1'b0;
    logic nest_virt = 1'b0, fgt_feat = 1'b0, fgt_top_en = 1'b0, fgt_trap = 1'b0;
    logic       res_vld;
    logic [1:0] res_code;
    logic [5:0] res_class;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_code_q[$];
    string      exp_tag_q[$];

    always #5 clk = ~clk;

    spec_restrict_trap_chk dut_i (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .cur_lvl(cur_lvl),
        .feat_present(feat_present), .lvl2_impl(lvl2_impl), .lvl2_act(lvl2_act),
        .lvl3_impl(lvl3_impl), .usr_en_l1(usr_en_l1), .usr_en_l2(usr_en_l2),
        .host_ext(host_ext), .trap_gen(trap_gen), .nest_virt(nest_virt),
        .fgt_feat(fgt_feat), .fgt_top_en(fgt_top_en), .fgt_trap(fgt_trap),
        .res_vld(res_vld), .res_code(res_code), .res_class(res_class)
    );

    // Driver: applies one issue on a falling edge and queues the expectation.
    task automatic issue(input string tag, input logic [1:0] lvl, input logic [1:0] exp,
                         input logic ft, input logic l2i, input logic l2a, input logic l3i,
                         input logic u1, input logic u2, input logic hx, input logic tg,
                         input logic nv, input logic ff, input logic fe, input logic fb);
        @(negedge clk);
        cur_lvl = lvl; feat_present = ft; lvl2_impl = l2i; lvl2_act = l2a;
        lvl3_impl = l3i; usr_en_l1 = u1; usr_en_l2 = u2; host_ext = hx;
        trap_gen = tg; nest_virt = nv; fgt_feat = ff; fgt_top_en = fe; fgt_trap = fb;
        issue_vld = 1'b1;
        exp_code_q.push_back(exp);
        exp_tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            issue_vld = 1'b0;
        end
    endtask

    // Monitor: pops one expectation per valid result.
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_vld) begin
                checks++;
                if (exp_code_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2: res_vld=1 expected 0 (no issue pending)");
                end else begin
                    logic [1:0] e;
                    logic [5:0] ec;
                    string t;
                    e = exp_code_q.pop_front();
                    t = exp_tag_q.pop_front();
                    ec = (e == 2'd1 || e == 2'd2) ? 6'h18 : 6'h00;
                    if (res_code !== e || res_class !== ec) begin
                        errors++;
                        $display("FAIL %s R9: code=%0d class=0x%0h expected code=%0d class=0x%0h",
                                 t, res_code, res_class, e, ec);
                    end
                end
            end
        end
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (res_vld !== 1'b0) begin
            errors++;
            $display("FAIL R1: res_vld=%b expected 0", res_vld);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        checks++;
        if (res_vld !== 1'b0) begin
            errors++;
            $display("FAIL R2: idle res_vld=%b expected 0", res_vld);
        end
        //              tag   lvl exp  ft l2i l2a l3i u1 u2 hx tg nv ff fe fb
        issue("R3_l2",  2'd2, 2'd3, 0, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1);
        issue("R3_l0",  2'd0, 2'd3, 0, 1, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        issue("R4_tg",  2'd0, 2'd2, 1, 1, 1, 0, 0, 1, 0, 1, 0, 0, 0, 0);
        issue("R4_el1", 2'd0, 2'd1, 1, 1, 1, 0, 0, 1, 0, 0, 0, 1, 1, 1);
        issue("R4_na",  2'd0, 2'd1, 1, 1, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0);
        idle(1);
        checks++;
        if (res_vld !== 1'b1) begin
            errors++;
            $display("FAIL R2: last result res_vld=%b expected 1", res_vld);
        end
        idle(1);
        checks++;
        if (res_vld !== 1'b0) begin
            errors++;
            $display("FAIL R2: after gap res_vld=%b expected 0", res_vld);
        end
        issue("R5_hit", 2'd0, 2'd2, 1, 1, 1, 0, 1, 0, 0, 0, 0, 1, 0, 1);
        issue("R5_top", 2'd0, 2'd0, 1, 1, 1, 1, 1, 0, 0, 0, 0, 1, 0, 1);
        issue("R5_l3e", 2'd0, 2'd2, 1, 1, 1, 1, 1, 0, 0, 0, 0, 1, 1, 1);
        issue("R5_bit", 2'd0, 2'd0, 1, 1, 1, 0, 1, 0, 0, 0, 0, 1, 1, 0);
        issue("R5_noff",2'd0, 2'd0, 1, 1, 1, 0, 1, 0, 0, 0, 0, 0, 1, 1);
        issue("R6_trap",2'd0, 2'd2, 1, 1, 1, 0, 1, 0, 1, 1, 0, 0, 0, 0);
        issue("R6_run", 2'd0, 2'd0, 1, 1, 1, 0, 0, 1, 1, 1, 0, 1, 1, 1);
        issue("R7_nv",  2'd1, 2'd2, 1, 1, 1, 0, 1, 1, 0, 0, 1, 0, 0, 0);
        issue("R7_fgt", 2'd1, 2'd2, 1, 1, 1, 0, 1, 1, 0, 0, 0, 1, 1, 1);
        issue("R7_run", 2'd1, 2'd0, 1, 1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        issue("R7_noel2",2'd1,2'd0, 1, 0, 0, 0, 1, 1, 0, 0, 0, 1, 1, 1);
        issue("R8_l2",  2'd2, 2'd0, 1, 1, 1, 1, 0, 0, 1, 1, 1, 1, 1, 1);
        issue("R8_l3",  2'd3, 2'd0, 1, 1, 1, 1, 0, 0, 1, 1, 1, 1, 1, 1);
        idle(3);
        checks++;
        if (exp_code_q.size() != 0) begin
            errors++;
            $display("FAIL R2: pending=%0d expected 0", exp_code_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule